// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Registers

This block keeps calendar time in packed BCD, on a 24-hour clock: seconds, minutes, hours, weekday, day of month, month and a two-digit year. The live time counters advance on a one-cycle 1 Hz tick. Software never sees them directly. It sees eight byte registers that sit at the top eight addresses of a byte-wide address space. After each tick, the time registers are reloaded from the counters in a single step.

Two bits in the control byte stop that reload. The freeze bit holds a coherent snapshot while software reads it, and the counters keep running underneath. The set bit also holds the snapshot, so that software can write a new time. When software clears the set bit, the time registers are copied into the live counters.

A stop flag in the seconds byte halts timekeeping and is driven out to the oscillator. The byte port is synchronous for writes. Reads are combinational from the selected register.

Top module: `bcd_rtc_snap`

## Requirements
- R1: After reset, the control, seconds, minutes and hours bytes read 0x00. Weekday, day of month and month read 0x01, year reads 0x00, and `osc_stop` is 0.
- R2: Bits that carry no field read back as 0. The masks are: seconds 0xFF, minutes 0x7F, hours 0x3F, weekday 0x47 (bit 6 is the test flag, bits 2:0 the weekday), day of month 0x3F, month 0x1F, year and control 0xFF. An address below the clock window reads 0x00, and a write to it changes no clock byte. `bus_rdata` is 0x00 whenever `bus_sel` is low.
- R3: The register offsets within the window are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. Seconds and minutes count in BCD from 00 to 59, and hours from 00 to 23. Each wrap carries into the next field within the same tick.
- R4: When the hours wrap, the weekday steps from 1 to 7 and wraps back to 1. The day of month wraps to 01 after the last day of its month: 31 days, or 30 for months 04, 06, 09 and 11. February has 29 days when the year is divisible by 4 (00 counts as divisible) and 28 days otherwise.
- R5: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R6: With both halt bits clear, all seven time bytes show the advanced count once two clock edges have passed after a tick is sampled.
- R7: While control bit 6 (freeze) is 1, the time bytes hold their values and the counters keep counting ticks. After freeze is cleared, the bytes keep their values until the next tick, which brings them up to the current count.
- R8: Setting a halt bit in the same cycle as a pending refresh does not cancel that refresh.
- R9: While control bit 7 (set) is 1, the time bytes are not refreshed and accept writes. A write that clears bit 7 while it is 1 copies bytes 1 to 7 into the counters on that edge. The stop and test flags are left out of the copy, and the load takes priority over a tick in the same cycle.
- R10: While bit 7 of the seconds byte is 1, `osc_stop` is 1 and ticks do not advance the counters.
- R11: The control byte reads back all eight written bits, including the calibration sign (bit 5) and magnitude (bits 4:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Byte port access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (13) | Byte address; the clock is the top eight locations |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed clock byte |
| osc_stop | output | 1 | Stop request to the oscillator |

## Verification
The bench builds the block with a 13-bit address and the divisible-by-four leap rule, so the window starts at 0x1FF8. This makes both the February 28 and February 29 wraps reachable, including year 00 as a leap year. A table of start times, each followed by one tick, drives every carry path from seconds up to the year wrap. Directed sequences then place halt writes against pending refreshes, tick while frozen, load on set release and stop the clock.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

   localparam int unsigned NUM_CLK_REGS = 8;
   localparam int unsigned OFS_W        = $clog2(NUM_CLK_REGS);

   // byte offsets inside the window; decoded by software
   localparam logic [OFS_W-1:0] OFS_CTRL = 3'd0;
   localparam logic [OFS_W-1:0] OFS_SEC  = 3'd1;
   localparam logic [OFS_W-1:0] OFS_YEAR = 3'd7;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] day;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam rtc_time_t RTC_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                       day: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   // bits that exist in each byte
   function automatic logic [7:0] byte_mask(input int unsigned ofs);
      case (ofs)
         2:       return 8'h7F;
         3:       return 8'h3F;
         4:       return 8'h47;
         5:       return 8'h3F;
         6:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   // user-only flags that a refresh leaves alone
   function automatic logic [7:0] keep_mask(input int unsigned ofs);
      case (ofs)
         1:       return 8'h80;
         4:       return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reset_byte(input int unsigned ofs);
      case (ofs)
         4, 5, 6: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
   import rtc_snap_pkg::*;
#(
   parameter bit LEAP_RULE = 1'b1
) (
   input  logic [7:0] month,
   input  logic [7:0] year,
   output logic [7:0] last_day
);

   logic feb_long;

   generate
      if (LEAP_RULE) begin : g_leap4
         // BCD year divisible by 4: tens even with ones 0/4/8, or tens odd with ones 2/6
         always_comb begin
            if (!year[4]) feb_long = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                                     (year[3:0] == 4'd8);
            else          feb_long = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
         end
      end else begin : g_no_leap
         assign feb_long = 1'b0;
      end
   endgenerate

   always_comb begin
      case (month)
         8'h02:                      last_day = feb_long ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase
   end

endmodule

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
   import rtc_snap_pkg::*;
#(
   parameter bit LEAP_RULE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cur
);

   logic [7:0] last_day;
   rtc_time_t  nxt;

   rtc_month_len #(.LEAP_RULE(LEAP_RULE)) u_mlen (
      .month    (cur.month),
      .year     (cur.year),
      .last_day (last_day)
   );

   // full carry chain settles in one cycle
   always_comb begin
      nxt = cur;
      if (cur.sec < 8'h59) nxt.sec = bcd_inc(cur.sec);
      else begin
         nxt.sec = 8'h00;
         if (cur.min < 8'h59) nxt.min = bcd_inc(cur.min);
         else begin
            nxt.min = 8'h00;
            if (cur.hour < 8'h23) nxt.hour = bcd_inc(cur.hour);
            else begin
               nxt.hour = 8'h00;
               nxt.day  = (cur.day >= 8'h07) ? 8'h01 : cur.day + 8'd1;
               if (cur.date < last_day) nxt.date = bcd_inc(cur.date);
               else begin
                  nxt.date = 8'h01;
                  if (cur.month < 8'h12) nxt.month = bcd_inc(cur.month);
                  else begin
                     nxt.month = 8'h01;
                     nxt.year  = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cur <= RTC_RESET;
      else if (load) cur <= load_val;
      else if (step) cur <= nxt;
   end

endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
   import rtc_snap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] ofs,
   input  logic [7:0]       wdata,
   input  logic             refresh,
   input  rtc_time_t        live,
   output logic [7:0]       ctrl,
   output rtc_time_t        usr_raw,
   output rtc_time_t        usr_clean,
   output logic [7:0]       rd_byte
);

   logic [7:0] live_b [NUM_CLK_REGS];
   logic [7:0] reg_b  [NUM_CLK_REGS];

   assign live_b[0] = 8'h00;
   assign live_b[1] = live.sec;
   assign live_b[2] = live.min;
   assign live_b[3] = live.hour;
   assign live_b[4] = live.day;
   assign live_b[5] = live.date;
   assign live_b[6] = live.month;
   assign live_b[7] = live.year;

   generate
      for (genvar g = 0; g < NUM_CLK_REGS; g++) begin : g_byte
         localparam logic [7:0] MSK  = byte_mask(g);
         localparam logic [7:0] KEEP = keep_mask(g);
         localparam logic [7:0] RSTV = reset_byte(g);
         localparam bit         TIME = (g != 0);
         logic [7:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                   q <= RSTV;
            else if (wr_en && ofs == OFS_W'(g))           q <= wdata & MSK;
            else if (refresh && TIME)                     q <= (live_b[g] & MSK & ~KEEP) | (q & KEEP);
         end
         assign reg_b[g] = q;
      end
   endgenerate

   assign ctrl    = reg_b[OFS_CTRL];
   assign rd_byte = reg_b[ofs];
   assign usr_raw = '{year: reg_b[7], month: reg_b[6], date: reg_b[5], day: reg_b[4],
                      hour: reg_b[3], min: reg_b[2], sec: reg_b[1]};

   // stop and test flags never enter the counters
   always_comb begin
      usr_clean     = usr_raw;
      usr_clean.sec = usr_raw.sec & 8'h7F;
      usr_clean.day = usr_raw.day & 8'h07;
   end

endmodule

// File: rtl/bcd_rtc_snap.sv
module bcd_rtc_snap
   import rtc_snap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 13,
   parameter bit          LEAP_RULE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              osc_stop
);

   localparam int unsigned WIN_W = ADDR_W - OFS_W;

   generate
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("ADDR_W must exceed the clock window offset width");
      end
   endgenerate

   logic             in_window;
   logic [OFS_W-1:0] ofs;
   logic             wr_en;
   logic             load;
   logic             tick_q;
   logic             refresh;
   logic             step;
   logic [7:0]       ctrl_q;
   logic [7:0]       rd_byte;
   rtc_time_t        live_t;
   rtc_time_t        usr_raw;
   rtc_time_t        usr_clean;

   assign in_window = &bus_addr[ADDR_W-1:OFS_W];
   assign ofs       = bus_addr[OFS_W-1:0];
   assign wr_en     = bus_sel && bus_we && in_window;
   // set bit falling under a control write
   assign load      = wr_en && (ofs == OFS_CTRL) && ctrl_q[7] && !bus_wdata[7];
   assign osc_stop  = usr_raw.sec[7];
   assign step      = tick_1hz && !osc_stop;
   // refresh one cycle after a tick; halt bits seen as registered
   assign refresh   = tick_q && !ctrl_q[7] && !ctrl_q[6];

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= tick_1hz;
   end

   rtc_live_counter #(.LEAP_RULE(LEAP_RULE)) u_live (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .load     (load),
      .load_val (usr_clean),
      .cur      (live_t)
   );

   rtc_user_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .ofs       (ofs),
      .wdata     (bus_wdata),
      .refresh   (refresh),
      .live      (live_t),
      .ctrl      (ctrl_q),
      .usr_raw   (usr_raw),
      .usr_clean (usr_clean),
      .rd_byte   (rd_byte)
   );

   assign bus_rdata = (bus_sel && !bus_we && in_window) ? rd_byte : 8'h00;

   logic unused_win;
   assign unused_win = ^WIN_W;

endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_we,
   input logic [7:0]  bus_rdata,
   input logic        osc_stop,
   input logic        load,
   input logic [7:0]  ctrl,
   input logic [55:0] live,
   input logic [55:0] usr
);

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[6] && !(bus_sel && bus_we)) |=> $stable(usr));

   // R9
   set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[7] && !(bus_sel && bus_we)) |=> $stable(usr));

   // R9
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (live[7:0] == {1'b0, $past(usr[6:0])}) &&
               (live[23:8] == $past(usr[23:8])) &&
               (live[31:24] == {5'b0, $past(usr[26:24])}) &&
               (live[55:32] == $past(usr[55:32])));

   // R10
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop && !load) |=> $stable(live));

   // R3
   time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[7:0] <= 8'h59) && (live[15:8] <= 8'h59) && (live[23:16] <= 8'h23));

   // R4
   day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[31:24] >= 8'h01) && (live[31:24] <= 8'h07));

   // R5
   month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[47:40] >= 8'h01) && (live[47:40] <= 8'h12) && (live[55:48] <= 8'h99));

   // R2
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == 8'h00));

endmodule

bind bcd_rtc_snap rtc_snap_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .osc_stop  (osc_stop),
   .load      (load),
   .ctrl      (ctrl_q),
   .live      (live_t),
   .usr       (usr_raw)
);

// File: tb/bcd_rtc_snap_bench.sv
module bcd_rtc_snap_bench;

   localparam int    CLK_P  = 10;
   localparam int    AW     = 13;
   localparam [12:0] BASE   = 13'h1FF8;
   localparam int    NVEC   = 10;

   // {start time, expected after one tick}; each time {yr,mo,dt,dy,hr,mi,se}
   localparam logic [111:0] VEC [NVEC] = '{
      {56'h24_06_15_03_12_34_56, 56'h24_06_15_03_12_34_57},
      {56'h24_06_15_03_00_00_59, 56'h24_06_15_03_00_01_00},
      {56'h24_06_15_03_09_59_59, 56'h24_06_15_03_10_00_00},
      {56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00},
      {56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00},
      {56'h24_02_28_02_23_59_59, 56'h24_02_29_03_00_00_00},
      {56'h24_02_29_03_23_59_59, 56'h24_03_01_04_00_00_00},
      {56'h24_04_30_05_23_59_59, 56'h24_05_01_06_00_00_00},
      {56'h24_05_30_06_23_59_59, 56'h24_05_31_07_00_00_00},
      {56'h00_02_28_01_23_59_59, 56'h00_02_29_02_00_00_00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_1hz = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          osc_stop;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bcd_rtc_snap #(.ADDR_W(AW), .LEAP_RULE(1'b1)) u_bcd_rtc_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_1hz  (tick_1hz),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .osc_stop  (osc_stop)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // returns after the refresh edge has passed
   task automatic tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_time(output logic [55:0] t);
      logic [7:0] b;
      for (int k = 1; k <= 7; k++) begin
         bus_rd(BASE + AW'(k), b);
         t[8*k-8 +: 8] = b;
      end
   endtask

   task automatic set_time(input logic [55:0] t);
      bus_wr(BASE, 8'h80);
      for (int k = 1; k <= 7; k++) bus_wr(BASE + AW'(k), t[8*k-8 +: 8]);
      bus_wr(BASE, 8'h00);
   endtask

   function automatic string vtag(input int i);
      if (i < 3)  return "R3 R6 vector";
      if (i == 3) return "R5 R6 vector";
      return "R4 R6 vector";
   endfunction

   initial begin
      logic [55:0] t;
      logic [7:0]  b;
      logic [63:0] all;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 8; k++) begin
         bus_rd(BASE + AW'(k), b);
         all[8*k +: 8] = b;
      end
      chk("R1 reset bytes", all, 64'h00_01_01_01_00_00_00_00);
      chk("R1 osc_stop", {63'b0, osc_stop}, 64'd0);

      // table walk: load, one tick, compare
      for (int i = 0; i < NVEC; i++) begin
         set_time(VEC[i][111:56]);
         tick();
         read_time(t);
         chk(vtag(i), {8'h0, t}, {8'h0, VEC[i][55:0]});
      end

      // R11 control readback
      bus_wr(BASE, 8'h3F);
      bus_rd(BASE, b);
      chk("R11 control bits", {56'h0, b}, {56'h0, 8'h3F});
      bus_wr(BASE, 8'h00);

      // R2 field masks and out-of-window access
      bus_wr(BASE, 8'h80);
      bus_wr(BASE + 13'd2, 8'hFF);
      bus_rd(BASE + 13'd2, b);
      chk("R2 minutes mask", {56'h0, b}, {56'h0, 8'h7F});
      bus_wr(BASE + 13'd4, 8'hFF);
      bus_rd(BASE + 13'd4, b);
      chk("R2 weekday mask", {56'h0, b}, {56'h0, 8'h47});
      bus_wr(BASE + 13'd6, 8'hFF);
      bus_rd(BASE + 13'd6, b);
      chk("R2 month mask", {56'h0, b}, {56'h0, 8'h1F});
      bus_wr(BASE + 13'd2, 8'h00);
      bus_wr(BASE + 13'd4, 8'h01);
      bus_wr(BASE + 13'd6, 8'h01);
      bus_wr(BASE, 8'h00);
      bus_wr(13'h1FF7, 8'hAA);
      bus_rd(13'h1FF7, b);
      chk("R2 below window reads zero", {56'h0, b}, 64'h0);
      bus_rd(BASE, b);
      chk("R2 below-window write ignored", {56'h0, b}, 64'h0);

      // R7 freeze while counters run
      set_time(56'h24_01_10_03_10_00_00);
      tick(); tick(); tick();
      bus_rd(BASE + 13'd1, b);
      chk("R7 running before freeze", {56'h0, b}, {56'h0, 8'h03});
      bus_wr(BASE, 8'h40);
      tick(); tick();
      bus_rd(BASE + 13'd1, b);
      chk("R7 frozen snapshot", {56'h0, b}, {56'h0, 8'h03});
      bus_wr(BASE, 8'h00);
      bus_rd(BASE + 13'd1, b);
      chk("R7 no catch-up before tick", {56'h0, b}, {56'h0, 8'h03});
      tick();
      bus_rd(BASE + 13'd1, b);
      chk("R7 catch-up on next tick", {56'h0, b}, {56'h0, 8'h06});

      // R8 halt written on the refresh edge
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = BASE; bus_wdata = 8'h40;
      @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
      bus_rd(BASE + 13'd1, b);
      chk("R8 pending refresh completes", {56'h0, b}, {56'h0, 8'h07});
      tick();
      bus_rd(BASE + 13'd1, b);
      chk("R8 later refresh held", {56'h0, b}, {56'h0, 8'h07});
      bus_wr(BASE, 8'h00);

      // R9 set mode: writes held, no refresh, load on release
      bus_wr(BASE, 8'h80);
      bus_wr(BASE + 13'd1, 8'h30);
      tick();
      bus_rd(BASE + 13'd1, b);
      chk("R9 no refresh while set", {56'h0, b}, {56'h0, 8'h30});
      bus_wr(BASE, 8'h00);
      tick();
      bus_rd(BASE + 13'd1, b);
      chk("R9 load on release", {56'h0, b}, {56'h0, 8'h31});

      // R10 stop flag
      bus_wr(BASE, 8'h80);
      bus_wr(BASE + 13'd1, 8'h80);
      bus_wr(BASE, 8'h00);
      chk("R10 osc_stop high", {63'b0, osc_stop}, 64'd1);
      tick(); tick();
      bus_rd(BASE + 13'd1, b);
      chk("R10 stopped seconds", {56'h0, b}, {56'h0, 8'h80});
      bus_wr(BASE, 8'h80);
      bus_wr(BASE + 13'd1, 8'h00);
      bus_wr(BASE, 8'h00);
      chk("R10 osc_stop low", {63'b0, osc_stop}, 64'd0);
      tick();
      bus_rd(BASE + 13'd1, b);
      chk("R10 restarted seconds", {56'h0, b}, {56'h0, 8'h01});

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule